// File: doc/BRIEF.md
# Serial LED Packet Command Decoder

This block sits behind a two-wire serial input (data plus clock) and turns framed command packets into per-channel PWM duty values. Both serial lines are brought into the system clock domain through flop synchronisers. Each edge of the serial clock is detected in that domain. Bits are collected MSB first into a byte, and a byte is handed to the decoder only when its eighth serial clock falls.

A packet opens with the byte 0xFF and carries four more fields in order. The first is a slave address, which must equal the local ID pins zero-extended to eight bits. The second is a sub-address that names the first channel to write. The third is a run of data bytes. The packet closes with the byte 0x81. Each data byte writes its low seven bits into one of 24 duty registers, and the channel index advances by one after each write. Channels are indexed red, green, blue for LED 0, then the same three for LED 1, and so on through LED 7. The index of colour c (R=0, G=1, B=2) of LED n is therefore 3n+c.

A pulse on the packet-done output tells the surrounding logic that a complete packet has ended. The PWM counters and the output drivers that consume the duty registers live elsewhere.

Top module: `led_packet_decoder`

## Requirements
- R1: A serial bit is sampled on the rising edge of the serial clock, and the first bit of a byte is its MSB. The byte is committed on the falling edge of its eighth serial clock, so no duty register changes between that eighth rising edge and the falling edge that follows it.
- R2: After 0xFF, a slave-address byte equal to {5'b00000, id} opens the packet for writing.
- R3: A slave-address byte that differs from {5'b00000, id} in any bit, including bits 7:3, causes every byte up to the next 0xFF to be ignored, with no register write and no packet-done pulse.
- R4: The first data byte is written to the channel named by the sub-address. Each further data byte goes to the next higher index. Channel 3n+c holds colour c (R=0, G=1, B=2) of LED n, and its value appears on duty bits [7*(3n+c)+6 : 7*(3n+c)].
- R5: A data byte that arrives while the index is past 23 is discarded. A sub-address of 24 or more makes the rest of the packet ignored.
- R6: Only bits 6:0 of a data byte are stored, and bit 7 is dropped.
- R7: The byte 0x81 in the data phase ends the packet and raises packet-done for exactly one system clock. Bytes other than 0xFF that follow are ignored.
- R8: The byte 0xFF received in any state restarts decoding at the slave-address phase.
- R9: While reset is high, every duty register reads zero and packet-done is low. After reset the decoder waits for a start byte.
- R10: Duty registers change only in the system clock that follows a byte commit, and at most one channel changes per committed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Active-high synchronous reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock line |
| id_pins | input | 3 | Local device identity |
| duty_flat | output | 168 | 24 packed 7-bit duty values, channel i at bits [7i+6:7i] |
| pkt_done | output | 1 | One-clock pulse when an end byte closes a packet |

## Verification
The hardest condition to reach is the window between the eighth rising edge of a data byte and the falling edge that follows it. At that point the whole byte already sits in the shift register but must not reach a channel yet. The bench builds its serial stream from single-bit steps. It can therefore stop with the serial clock held high on the final bit of a data byte, read the target channel, and only then release the clock and read it again. Restart from inside a packet is reached by injecting 0xFF as a data byte and as a slave address.

// File: rtl/ledpkt_pkg.sv
package ledpkt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SUB,
      ST_DATA,
      ST_SKIP
   } dec_state_t;
endpackage

// File: rtl/ledpkt_sync.sv
module ledpkt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad
      $error("ledpkt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/ledpkt_deframer.sv
module ledpkt_deframer #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_data,
   input  logic              ser_clk,
   output logic [BYTE_W-1:0] byte_q,
   output logic              byte_stb
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   logic              data_s, clk_s, clk_d;
   logic              clk_rise, clk_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;

   ledpkt_sync #(.STAGES(SYNC_STAGES)) i_sync_data (
      .clk(clk), .rst(rst), .din(ser_data), .dout(data_s));
   ledpkt_sync #(.STAGES(SYNC_STAGES)) i_sync_clk (
      .clk(clk), .rst(rst), .din(ser_clk), .dout(clk_s));

   always_ff @(posedge clk) begin
      if (rst) clk_d <= 1'b0;
      else     clk_d <= clk_s;
   end

   assign clk_rise = clk_s & ~clk_d;
   assign clk_fall = ~clk_s & clk_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         byte_q   <= '0;
         byte_stb <= 1'b0;
      end else begin
         byte_stb <= 1'b0;
         if (clk_rise && bit_cnt < CNT_W'(BYTE_W)) begin
            shreg   <= {shreg[BYTE_W-2:0], data_s};
            bit_cnt <= bit_cnt + 1'b1;
         end else if (clk_fall && bit_cnt == CNT_W'(BYTE_W)) begin
            byte_q   <= shreg;
            byte_stb <= 1'b1;
            bit_cnt  <= '0;
         end
      end
   end
endmodule

// File: rtl/ledpkt_fsm.sv
module ledpkt_fsm
   import ledpkt_pkg::*;
#(
   parameter int              NUM_CH     = 24,
   parameter int              DUTY_W     = 7,
   parameter int              ID_W       = 3,
   parameter int              BYTE_W     = 8,
   parameter int              IDX_W      = 5,
   parameter logic [BYTE_W-1:0] START_CODE = 8'hFF,
   parameter logic [BYTE_W-1:0] END_CODE   = 8'h81
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BYTE_W-1:0] byte_q,
   input  logic              byte_stb,
   input  logic [ID_W-1:0]   id_pins,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DUTY_W-1:0] wr_data,
   output logic              pkt_done
);
   dec_state_t        state;
   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-1:0] local_addr;
   logic              is_start, is_end;

   assign local_addr = {{(BYTE_W-ID_W){1'b0}}, id_pins};
   assign is_start   = byte_q == START_CODE;
   assign is_end     = byte_q == END_CODE;

   assign wr_en   = byte_stb && state == ST_DATA && !is_start && !is_end
                    && idx < IDX_W'(NUM_CH);
   assign wr_idx  = idx;
   assign wr_data = byte_q[DUTY_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         idx      <= '0;
         pkt_done <= 1'b0;
      end else begin
         pkt_done <= 1'b0;
         if (byte_stb) begin
            if (is_start) begin
               state <= ST_ADDR;
            end else begin
               case (state)
                  ST_ADDR: state <= (byte_q == local_addr) ? ST_SUB : ST_SKIP;
                  ST_SUB: begin
                     if (byte_q < BYTE_W'(NUM_CH)) begin
                        idx   <= byte_q[IDX_W-1:0];
                        state <= ST_DATA;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
                  ST_DATA: begin
                     if (is_end) begin
                        pkt_done <= 1'b1;
                        state    <= ST_IDLE;
                     end else if (wr_en) begin
                        idx <= idx + 1'b1;
                     end
                  end
                  default: state <= state;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/ledpkt_chregs.sv
module ledpkt_chregs #(
   parameter int NUM_CH = 24,
   parameter int DUTY_W = 7,
   parameter int IDX_W  = 5
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [DUTY_W-1:0]        wr_data,
   output logic [NUM_CH*DUTY_W-1:0] duty_flat
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [DUTY_W-1:0] duty_r;
      always_ff @(posedge clk) begin
         if (rst)                                       duty_r <= '0;
         else if (wr_en && wr_idx == IDX_W'(ch))        duty_r <= wr_data;
      end
      assign duty_flat[ch*DUTY_W +: DUTY_W] = duty_r;
   end
endmodule

// File: rtl/led_packet_decoder.sv
module led_packet_decoder #(
   parameter int NUM_CH      = 24,
   parameter int DUTY_W      = 7,
   parameter int ID_W        = 3,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ser_data,
   input  logic                     ser_clk,
   input  logic [ID_W-1:0]          id_pins,
   output logic [NUM_CH*DUTY_W-1:0] duty_flat,
   output logic                     pkt_done
);
   localparam int IDX_W = $clog2(NUM_CH + 1);

   if (DUTY_W >= BYTE_W) begin : g_bad_duty
      $error("led_packet_decoder: DUTY_W must be below BYTE_W");
   end
   if (ID_W >= BYTE_W) begin : g_bad_id
      $error("led_packet_decoder: ID_W must be below BYTE_W");
   end
   if (IDX_W > BYTE_W) begin : g_bad_idx
      $error("led_packet_decoder: NUM_CH too large for sub-address byte");
   end

   logic [BYTE_W-1:0] byte_q;
   logic              byte_stb;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [DUTY_W-1:0] wr_data;

   ledpkt_deframer #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) i_deframer (
      .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
      .byte_q(byte_q), .byte_stb(byte_stb));

   ledpkt_fsm #(
      .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .ID_W(ID_W), .BYTE_W(BYTE_W),
      .IDX_W(IDX_W), .START_CODE(8'hFF), .END_CODE(8'h81)
   ) i_fsm (
      .clk(clk), .rst(rst), .byte_q(byte_q), .byte_stb(byte_stb),
      .id_pins(id_pins), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .pkt_done(pkt_done));

   ledpkt_chregs #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .IDX_W(IDX_W)) i_chregs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .duty_flat(duty_flat));
endmodule

// File: rtl/ledpkt_chk.sv
module ledpkt_chk #(
   parameter int NUM_CH = 24,
   parameter int DUTY_W = 7,
   parameter int BYTE_W = 8
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     byte_stb,
   input logic [BYTE_W-1:0]        byte_q,
   input logic [NUM_CH*DUTY_W-1:0] duty_flat,
   input logic                     pkt_done
);
   logic [NUM_CH*DUTY_W-1:0] prev_duty;
   logic [NUM_CH-1:0]        changed;

   always_ff @(posedge clk) begin
      if (rst) prev_duty <= '0;
      else     prev_duty <= duty_flat;
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
      assign changed[ch] = duty_flat[ch*DUTY_W +: DUTY_W]
                           != prev_duty[ch*DUTY_W +: DUTY_W];
   end

   assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
      pkt_done |=> !pkt_done);

   assert_done_cause_R7: assert property (@(posedge clk) disable iff (rst)
      pkt_done |-> ($past(byte_stb) && $past(byte_q) == 8'h81));

   assert_quiet_between_bytes_R10: assert property (@(posedge clk) disable iff (rst)
      !byte_stb |=> $stable(duty_flat));

   assert_one_channel_R10: assert property (@(posedge clk) disable iff (rst)
      $countones(changed) <= 1);
endmodule

bind led_packet_decoder ledpkt_chk #(
   .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .BYTE_W(BYTE_W)
) i_chk (
   .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_q(byte_q),
   .duty_flat(duty_flat), .pkt_done(pkt_done));

// File: tb/test_led_packet_decoder.sv
module test_led_packet_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BIT   = 6;
   localparam int NCH        = 24;
   localparam int DW         = 7;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            ser_data = 1'b0;
   logic            ser_clk = 1'b0;
   logic [2:0]      id_pins = 3'd5;
   logic [NCH*DW-1:0] duty_flat;
   logic            pkt_done;

   int checks = 0;
   int errors = 0;
   int done_cycles = 0;
   bit finished = 1'b0;
   logic [DW-1:0] exp_duty [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   led_packet_decoder i_led_packet_decoder (
      .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
      .id_pins(id_pins), .duty_flat(duty_flat), .pkt_done(pkt_done));

   always @(posedge clk) if (pkt_done) done_cycles++;

   task automatic wait_clks(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_bit(input logic b);
      ser_data = b;
      wait_clks(HALF_BIT);
      ser_clk = 1'b1;
      wait_clks(HALF_BIT);
      ser_clk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic settle();
      wait_clks(HALF_BIT + 2);
   endtask

   function automatic logic [DW-1:0] ch_val(input int ch);
      return duty_flat[ch*DW +: DW];
   endfunction

   task automatic check_all(input string tag);
      int bad = -1;
      checks++;
      for (int ch = 0; ch < NCH; ch++)
         if (bad < 0 && ch_val(ch) !== exp_duty[ch]) bad = ch;
      if (bad >= 0) begin
         errors++;
         $display("FAIL %s channel %0d got %h expected %h", tag, bad,
                  ch_val(bad), exp_duty[bad]);
      end
   endtask

   task automatic check_done(input string tag, input int exp_n);
      checks++;
      if (done_cycles != exp_n) begin
         errors++;
         $display("FAIL %s packet-done cycles got %0d expected %0d", tag,
                  done_cycles, exp_n);
      end
   endtask

   task automatic clear_exp();
      for (int ch = 0; ch < NCH; ch++) exp_duty[ch] = '0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      wait_clks(4);
      rst = 1'b0;
      wait_clks(2);
      clear_exp();
   endtask

   // R9: reset state
   task automatic t_reset();
      check_all("R9");
      checks++;
      if (pkt_done !== 1'b0) begin
         errors++;
         $display("FAIL R9 pkt_done got %b expected 0", pkt_done);
      end
   endtask

   // R2, R4, R7: basic packet at channel 0, colour order R0 G0 B0
   task automatic t_basic();
      done_cycles = 0;
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'h00);
      send_byte(8'h10); send_byte(8'h22); send_byte(8'h33);
      send_byte(8'h81); settle();
      exp_duty[0] = 7'h10; exp_duty[1] = 7'h22; exp_duty[2] = 7'h33;
      check_all("R2 R4");
      check_done("R7", 1);
   endtask

   // R4: mid-table start, G3 = index 10
   task automatic t_mid();
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'd10);
      send_byte(8'h41); send_byte(8'h42); send_byte(8'h43);
      send_byte(8'h81); settle();
      exp_duty[10] = 7'h41; exp_duty[11] = 7'h42; exp_duty[12] = 7'h43;
      check_all("R4");
   endtask

   // R5: writes past 23 discarded; sub-address 24 ignored
   task automatic t_edge();
      done_cycles = 0;
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'd22);
      send_byte(8'h5A); send_byte(8'h5B); send_byte(8'h5C); send_byte(8'h5D);
      send_byte(8'h81); settle();
      exp_duty[22] = 7'h5A; exp_duty[23] = 7'h5B;
      check_all("R5 past end");
      check_done("R5 R7", 1);
      done_cycles = 0;
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'd24);
      send_byte(8'h55); send_byte(8'h81); settle();
      check_all("R5 sub 24");
      check_done("R5 sub 24", 0);
   endtask

   // R3: address mismatch, including upper bits
   task automatic t_mismatch();
      done_cycles = 0;
      send_byte(8'hFF); send_byte(8'h06); send_byte(8'h00);
      send_byte(8'h44); send_byte(8'h81); settle();
      check_all("R3 low bits");
      send_byte(8'hFF); send_byte(8'h25); send_byte(8'h01);
      send_byte(8'h44); send_byte(8'h81); settle();
      check_all("R3 upper bits");
      check_done("R3", 0);
   endtask

   // R6: bit 7 dropped
   task automatic t_mask();
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'd4);
      send_byte(8'hC5); send_byte(8'h80); send_byte(8'h81); settle();
      exp_duty[4] = 7'h45; exp_duty[5] = 7'h00;
      check_all("R6");
   endtask

   // R8: restart from data phase and from skip state
   task automatic t_restart();
      done_cycles = 0;
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'd3); send_byte(8'h11);
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'd7); send_byte(8'h22);
      send_byte(8'h81); settle();
      exp_duty[3] = 7'h11; exp_duty[7] = 7'h22; exp_duty[4] = 7'h45;
      check_all("R8 data phase");
      check_done("R8", 1);
      send_byte(8'hFF); send_byte(8'h06); send_byte(8'hFF); send_byte(8'h05);
      send_byte(8'd1); send_byte(8'h3C); send_byte(8'h81); settle();
      exp_duty[1] = 7'h3C;
      check_all("R8 skip state");
   endtask

   // R7: bytes after end byte ignored
   task automatic t_after_end();
      send_byte(8'h12); send_byte(8'h34); settle();
      check_all("R7 after end");
   endtask

   // R1: MSB-first and commit on falling edge of eighth clock
   task automatic t_commit_edge();
      logic [7:0] v = 8'h2A;
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'd2);
      for (int i = 7; i >= 1; i--) send_bit(v[i]);
      ser_data = v[0];
      wait_clks(HALF_BIT);
      ser_clk = 1'b1;
      wait_clks(10);
      check_all("R1 held high");
      ser_clk = 1'b0;
      settle();
      exp_duty[2] = 7'h2A;
      check_all("R1 after fall");
      send_byte(8'h81); settle();
   endtask

   // R2: different ID value
   task automatic t_id0();
      id_pins = 3'd0;
      wait_clks(4);
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'd9);
      send_byte(8'h77); send_byte(8'h81); settle();
      check_all("R2 old id");
      send_byte(8'hFF); send_byte(8'h00); send_byte(8'd9);
      send_byte(8'h77); send_byte(8'h81); settle();
      exp_duty[9] = 7'h77;
      check_all("R2 id 0");
      id_pins = 3'd5;
   endtask

   // R9: reset mid-packet clears state and registers
   task automatic t_reset_mid();
      send_byte(8'hFF); send_byte(8'h05); send_byte(8'd0);
      do_reset();
      check_all("R9 mid");
      send_byte(8'h66); send_byte(8'h81); settle();
      check_all("R9 decoder idle");
   endtask

   initial begin
      clear_exp();
      wait_clks(4);
      rst = 1'b0;
      wait_clks(2);
      t_reset();
      t_basic();
      t_mid();
      t_edge();
      t_mismatch();
      t_mask();
      t_restart();
      t_after_end();
      t_commit_edge();
      t_id0();
      t_reset_mid();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule